// File: doc/BRIEF.md
# AXI Burst Rule Checker

A passive observer for one direction of an AXI port: one address channel and the data channel that goes with it. It never drives the bus. Every accepted address handshake is tested at once against the burst rules. These rules cover the reserved burst type, the length range, the permitted lengths and start alignment of wrapping bursts, and the 4 KB page limit for incrementing bursts. A mode input picks the length decoding: 4-bit lengths (older protocol revision, `axi4_mode` low) or 8-bit lengths (`axi4_mode` high).

Each accepted burst enters an in-order queue that holds its decoded beat count. The data channel is tracked against the burst at the head of the queue. A beat is counted on every data handshake, whatever its data or byte strobes hold, because bursts cannot be cut short. The checker flags a LAST that arrives before the final beat, a final beat that lacks LAST, a data beat with no burst outstanding, and an address accepted while the queue is full.

Each rule has a one-cycle pulse output and a sticky flag. The flags are meant for a simulation monitor, or for an on-chip debug status register in a larger system.

Top module: `axi_burst_auditor`

## Requirements
- R1: An accepted address with burst type 2'b11 (reserved; 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping) raises rule bit 0.
- R2: With `axi4_mode` low the beat count is `a_len[3:0]`+1 for every type, and any accepted address with a nonzero `a_len[7:4]` raises rule bit 1.
- R3: With `axi4_mode` high the beat count is `a_len`+1, an incrementing burst of up to 256 beats raises nothing, and a fixed or wrapping burst with `a_len` above 15 raises rule bit 2.
- R4: A wrapping burst whose decoded beat count is not 2, 4, 8 or 16 raises rule bit 3.
- R5: A wrapping burst whose start address has any of its low `a_size` bits set raises rule bit 4.
- R6: An incrementing burst raises rule bit 5 when start + beats×2^`a_size` − 1 lies in a different 4 KB page than the start address.
- R7: A data beat carrying LAST before the burst's final beat raises rule bit 6 and closes that burst; the next beat belongs to the next queued burst.
- R8: The final beat of a burst without LAST raises rule bit 7 and closes that burst.
- R9: A data beat while no burst is queued and no address is accepted in the same cycle raises rule bit 8. An address and a beat accepted together on an empty queue pair up directly.
- R10: Up to DEPTH bursts are held and matched to data in acceptance order. An address accepted while DEPTH bursts are outstanding raises rule bit 9 and is not queued.
- R11: `err_pulse` shows a violation for exactly the one cycle after the handshake that caused it. Address rule bits 0 to 5 only follow an address handshake, and data rule bits 6 to 8 only follow a data handshake.
- R12: `err_sticky` bits stay set until `clr_sticky` is high at a clock edge. A violation detected at that same edge still sets its bit.
- R13: Synchronous `rst` empties the queue, zeroes the beat counter and clears every pulse and sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_sticky | input | 1 | Synchronous clear of all sticky flags |
| axi4_mode | input | 1 | 1: 8-bit length decode, 0: 4-bit length decode |
| a_valid | input | 1 | Address channel valid |
| a_ready | input | 1 | Address channel ready |
| a_addr | input | ADDR_W | Burst start address |
| a_len | input | 8 | Burst length field (beats − 1) |
| a_size | input | 3 | Bytes per beat as log2 |
| a_burst | input | 2 | Burst type |
| d_valid | input | 1 | Data channel valid |
| d_ready | input | 1 | Data channel ready |
| d_last | input | 1 | Data channel LAST marker |
| err_pulse | output | 10 | One-cycle violation pulses, one per rule bit |
| err_sticky | output | 10 | Held violation flags, one per rule bit |

## Verification
On every cycle, the assertions check the timing contract of the flags. Address rules only follow address handshakes and data rules only follow data handshakes. Sticky bits never drop without a clear and always cover the current pulses. The reserved-type, 4-bit-mode length and wrap-length rules are checked directly against the address ports. The arithmetic of each rule needs the bench's scenarios: the 4 KB crossing, wrap alignment, and length decode in both modes, swept over types, lengths, sizes and page offsets. The same holds for beat counting against real bursts, for early and missing LAST recovery, for queue overflow and orphan beats, and for the same-cycle pairing of address and data.

// File: rtl/axi_burst_audit_pkg.sv
package axi_burst_audit_pkg;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_kind_e;

  localparam int N_RULES      = 10;
  localparam int N_ADDR_RULES = 6;

  localparam int RB_TYPE      = 0;
  localparam int RB_LEN_HI    = 1;
  localparam int RB_LEN_LONG  = 2;
  localparam int RB_WRAP_LEN  = 3;
  localparam int RB_WRAP_ALGN = 4;
  localparam int RB_PAGE      = 5;
  localparam int RB_EARLY     = 6;
  localparam int RB_NO_LAST   = 7;
  localparam int RB_ORPHAN    = 8;
  localparam int RB_OVERFLOW  = 9;

endpackage

// File: rtl/axi_addr_rules.sv
module axi_addr_rules
  import axi_burst_audit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    axi4_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              len,
  input  logic [2:0]              size,
  input  logic [1:0]              burst,
  output logic [7:0]              beats_m1,
  output logic [N_ADDR_RULES-1:0] viol
);

  localparam int SUM_W  = ADDR_W + 1;
  localparam int SPAN_W = 17;

  burst_kind_e             kind;
  logic [SPAN_W-1:0]       span;
  logic [SUM_W-1:0]        last_byte;
  logic [ADDR_W-1:0]       size_mask;
  logic                    crosses_page;
  logic                    misaligned;
  logic                    wrap_len_ok;

  always_comb begin
    kind         = burst_kind_e'(burst);
    beats_m1     = axi4_mode ? len : {4'b0000, len[3:0]};
    span         = ({9'b0, beats_m1} + SPAN_W'(1)) << size;
    last_byte    = {1'b0, addr} + SUM_W'(span) - SUM_W'(1);
    crosses_page = last_byte[SUM_W-1:12] != {1'b0, addr[ADDR_W-1:12]};
    size_mask    = (ADDR_W'(1) << size) - ADDR_W'(1);
    misaligned   = |(addr & size_mask);
    wrap_len_ok  = (beats_m1 == 8'd1) || (beats_m1 == 8'd3) ||
                   (beats_m1 == 8'd7) || (beats_m1 == 8'd15);

    viol               = '0;
    viol[RB_TYPE]      = (kind == BT_RSVD);
    viol[RB_LEN_HI]    = !axi4_mode && (len[7:4] != 4'd0);
    viol[RB_LEN_LONG]  = axi4_mode && (len[7:4] != 4'd0) &&
                         ((kind == BT_FIXED) || (kind == BT_WRAP));
    viol[RB_WRAP_LEN]  = (kind == BT_WRAP) && !wrap_len_ok;
    viol[RB_WRAP_ALGN] = (kind == BT_WRAP) && misaligned;
    viol[RB_PAGE]      = (kind == BT_INCR) && crosses_page;
  end

endmodule

// File: rtl/burst_len_fifo.sv
module burst_len_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] fill;

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/beat_tracker.sv
module beat_tracker (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat,
  input  logic       beat_last,
  input  logic       head_valid,
  input  logic [7:0] head_m1,
  output logic       close,
  output logic       early_last,
  output logic       missing_last,
  output logic       orphan
);

  logic [7:0] done_cnt;
  logic       at_final;
  logic       owned;

  always_comb begin
    owned        = beat && head_valid;
    at_final     = (done_cnt == head_m1);
    close        = owned && (at_final || beat_last);
    early_last   = owned && beat_last && !at_final;
    missing_last = owned && at_final && !beat_last;
    orphan       = beat && !head_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) done_cnt <= '0;
    else if (owned) done_cnt <= close ? 8'd0 : done_cnt + 8'd1;
  end

endmodule

// File: rtl/rule_flags.sv
module rule_flags #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] hit,
  output logic [N-1:0] pulse,
  output logic [N-1:0] sticky
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        pulse[i]  <= 1'b0;
        sticky[i] <= 1'b0;
      end else begin
        pulse[i]  <= hit[i];
        sticky[i] <= (sticky[i] && !clr) || hit[i];
      end
    end
  end

endmodule

// File: rtl/axi_burst_auditor.sv
module axi_burst_auditor
  import axi_burst_audit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_sticky,
  input  logic              axi4_mode,
  input  logic              a_valid,
  input  logic              a_ready,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [7:0]        a_len,
  input  logic [2:0]        a_size,
  input  logic [1:0]        a_burst,
  input  logic              d_valid,
  input  logic              d_ready,
  input  logic              d_last,
  output logic [9:0]        err_pulse,
  output logic [9:0]        err_sticky
);

  logic                    a_fire;
  logic                    d_fire;
  logic [7:0]              new_m1;
  logic [N_ADDR_RULES-1:0] addr_viol;
  logic [7:0]              head_m1;
  logic                    q_empty;
  logic                    q_full;
  logic                    head_valid;
  logic [7:0]              cur_m1;
  logic                    close;
  logic                    early_last;
  logic                    missing_last;
  logic                    orphan;
  logic                    q_pop;
  logic                    q_push;
  logic                    overflow;
  logic [N_RULES-1:0]      hit;

  assign a_fire = a_valid && a_ready;
  assign d_fire = d_valid && d_ready;

  axi_addr_rules #(.ADDR_W(ADDR_W)) u_rules (
    .axi4_mode (axi4_mode),
    .addr      (a_addr),
    .len       (a_len),
    .size      (a_size),
    .burst     (a_burst),
    .beats_m1  (new_m1),
    .viol      (addr_viol)
  );

  // An empty queue lets a same-cycle address pair directly with the beat.
  assign head_valid = !q_empty || a_fire;
  assign cur_m1     = q_empty ? new_m1 : head_m1;

  beat_tracker u_track (
    .clk          (clk),
    .rst          (rst),
    .beat         (d_fire),
    .beat_last    (d_last),
    .head_valid   (head_valid),
    .head_m1      (cur_m1),
    .close        (close),
    .early_last   (early_last),
    .missing_last (missing_last),
    .orphan       (orphan)
  );

  assign q_pop    = close && !q_empty;
  assign overflow = a_fire && q_full && !q_pop;
  assign q_push   = a_fire && !overflow && !(q_empty && close);

  burst_len_fifo #(.DEPTH(DEPTH), .W(8)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .pop   (q_pop),
    .wdata (new_m1),
    .rdata (head_m1),
    .empty (q_empty),
    .full  (q_full)
  );

  always_comb begin
    hit                          = '0;
    hit[N_ADDR_RULES-1:0]        = a_fire ? addr_viol : '0;
    hit[RB_EARLY]                = early_last;
    hit[RB_NO_LAST]              = missing_last;
    hit[RB_ORPHAN]               = orphan;
    hit[RB_OVERFLOW]             = overflow;
  end

  rule_flags #(.N(N_RULES)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_sticky),
    .hit    (hit),
    .pulse  (err_pulse),
    .sticky (err_sticky)
  );

endmodule

// File: rtl/axi_burst_auditor_chk.sv
module axi_burst_auditor_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr_sticky,
  input logic       axi4_mode,
  input logic       a_valid,
  input logic       a_ready,
  input logic [7:0] a_len,
  input logic [1:0] a_burst,
  input logic       d_valid,
  input logic       d_ready,
  input logic [9:0] err_pulse,
  input logic [9:0] err_sticky
);

  // R1
  rsvd_type_chk: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready && a_burst == 2'b11) |=> err_pulse[0]);

  // R2
  short_len_chk: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready && !axi4_mode && a_len[7:4] != 4'd0) |=> err_pulse[1]);

  // R4
  wrap_len_chk: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready && a_burst == 2'b10 && axi4_mode &&
     !(a_len == 8'd1 || a_len == 8'd3 || a_len == 8'd7 || a_len == 8'd15))
    |=> err_pulse[3]);

  // R11
  addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_valid && a_ready) |=> (err_pulse[5:0] == 6'd0));

  // R11
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(d_valid && d_ready) |=> (err_pulse[8:6] == 3'd0));

  // R12
  sticky_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (err_pulse & ~err_sticky) == 10'd0);

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_sticky |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  // R12
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_sticky |=> (err_sticky == err_pulse));

endmodule

bind axi_burst_auditor axi_burst_auditor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_sticky (clr_sticky),
  .axi4_mode  (axi4_mode),
  .a_valid    (a_valid),
  .a_ready    (a_ready),
  .a_len      (a_len),
  .a_burst    (a_burst),
  .d_valid    (d_valid),
  .d_ready    (d_ready),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky)
);

// File: tb/test_axi_burst_auditor.sv
module test_axi_burst_auditor;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DEPTH      = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clr_sticky = 1'b0;
  logic              axi4_mode = 1'b0;
  logic              a_valid = 1'b0;
  logic              a_ready = 1'b1;
  logic [ADDR_W-1:0] a_addr = '0;
  logic [7:0]        a_len = '0;
  logic [2:0]        a_size = '0;
  logic [1:0]        a_burst = '0;
  logic              d_valid = 1'b0;
  logic              d_ready = 1'b1;
  logic              d_last = 1'b0;
  logic [9:0]        err_pulse;
  logic [9:0]        err_sticky;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_burst_auditor #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_axi_burst_auditor (
    .clk (clk), .rst (rst), .clr_sticky (clr_sticky), .axi4_mode (axi4_mode),
    .a_valid (a_valid), .a_ready (a_ready), .a_addr (a_addr), .a_len (a_len),
    .a_size (a_size), .a_burst (a_burst), .d_valid (d_valid), .d_ready (d_ready),
    .d_last (d_last), .err_pulse (err_pulse), .err_sticky (err_sticky)
  );

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  function automatic logic [5:0] exp_addr(bit mode, longint addr, int len, int size, int bt);
    logic [5:0] e;
    int beats;
    longint bytes;
    beats = mode ? len + 1 : (len % 16) + 1;
    bytes = longint'(beats) << size;
    e = '0;
    e[0] = (bt == 3);
    e[1] = !mode && len > 15;
    e[2] = mode && (bt == 0 || bt == 2) && len > 15;
    e[3] = (bt == 2) && !(beats == 2 || beats == 4 || beats == 8 || beats == 16);
    e[4] = (bt == 2) && ((addr % (longint'(1) << size)) != 0);
    e[5] = (bt == 1) && (((addr + bytes - 1) / 4096) != (addr / 4096));
    return e;
  endfunction

  function automatic int len_pick(int i);
    case (i)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 5;   5: return 7;   6: return 8;   7: return 15;
      8: return 16;  9: return 19;  10: return 127; default: return 255;
    endcase
  endfunction

  function automatic logic [31:0] addr_pick(int i);
    case (i)
      0: return 32'h0000_2000;
      1: return 32'h0000_2FE0;
      2: return 32'h0000_2FFE;
      default: return 32'h0000_2F01;
    endcase
  endfunction

  // Entered and left at a falling edge.
  task automatic send_addr(bit mode, logic [31:0] addr, int len, int size, int bt, bit clr);
    axi4_mode = mode; a_addr = addr; a_len = 8'(len); a_size = 3'(size);
    a_burst = 2'(bt); a_valid = 1'b1; clr_sticky = clr;
    @(negedge clk);
    a_valid = 1'b0; clr_sticky = 1'b0;
  endtask

  task automatic send_beat(bit last);
    d_valid = 1'b1; d_last = last;
    @(negedge clk);
    d_valid = 1'b0; d_last = 1'b0;
  endtask

  task automatic run_beats(int n);
    for (int b = 0; b < n; b++) send_beat(b == n - 1);
  endtask

  task automatic clear_flags();
    clr_sticky = 1'b1;
    @(negedge clk);
    clr_sticky = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 19000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    check("R13 pulse after reset", err_pulse, 10'd0);
    check("R13 sticky after reset", err_sticky, 10'd0);

    // Address rule sweep, each burst run to completion (R1-R6 decode, R11, R12)
    for (int m = 0; m < 2; m++)
      for (int bt = 0; bt < 4; bt++)
        for (int li = 0; li < 12; li++)
          for (int sz = 0; sz < 3; sz++)
            for (int ai = 0; ai < 4; ai++) begin
              logic [5:0] e;
              int len;
              len = len_pick(li);
              e = exp_addr(m[0], longint'(addr_pick(ai)), len, sz, bt);
              send_addr(m[0], addr_pick(ai), len, sz, bt, 1'b1);
              // R1 R2 R3 R4 R5 R6 R11
              check("R1-6 address pulses", err_pulse, {4'b0000, e});
              run_beats(m ? len + 1 : (len % 16) + 1);
              // R2 R3 R12 length decode matches the beats sent
              check("R2/R3 decode and sticky", err_sticky, {4'b0000, e});
            end

    // R11 pulse lasts one cycle
    send_addr(1'b0, 32'h100, 0, 0, 3, 1'b1);
    @(negedge clk);
    check("R11 pulse gone", err_pulse, 10'd0);
    check("R12 sticky kept", err_sticky, 10'b0000000001);
    run_beats(1);

    // R7 early LAST, next burst starts fresh
    clear_flags();
    send_addr(1'b1, 32'h0, 3, 2, 1, 1'b0);
    send_addr(1'b1, 32'h40, 1, 2, 1, 1'b0);
    send_beat(1'b0);
    send_beat(1'b1);
    check("R7 early last pulse", err_pulse, 10'b0001000000);
    run_beats(2);
    check("R7 next burst clean", err_sticky, 10'b0001000000);

    // R8 missing LAST
    clear_flags();
    send_addr(1'b1, 32'h0, 1, 2, 1, 1'b0);
    send_addr(1'b1, 32'h40, 0, 2, 1, 1'b0);
    send_beat(1'b0);
    send_beat(1'b0);
    check("R8 missing last pulse", err_pulse, 10'b0010000000);
    run_beats(1);
    check("R8 next burst clean", err_sticky, 10'b0010000000);

    // R9 orphan beat
    clear_flags();
    send_beat(1'b1);
    check("R9 orphan pulse", err_pulse, 10'b0100000000);

    // R9 same-cycle address and beat on empty queue
    clear_flags();
    axi4_mode = 1'b1; a_addr = 32'h0; a_len = 8'd0; a_size = 3'd2; a_burst = 2'b01;
    a_valid = 1'b1; d_valid = 1'b1; d_last = 1'b1;
    @(negedge clk);
    a_valid = 1'b0; d_valid = 1'b0; d_last = 1'b0;
    check("R9 direct pairing", err_pulse, 10'd0);
    send_beat(1'b1);
    check("R9 queue left empty", err_pulse, 10'b0100000000);

    // R10 overflow and in-order matching
    clear_flags();
    for (int k = 0; k < DEPTH; k++) send_addr(1'b1, 32'h0, k, 0, 1, 1'b0);
    check("R10 full no error", err_sticky, 10'd0);
    send_addr(1'b1, 32'h0, 7, 0, 1, 1'b0);
    check("R10 overflow pulse", err_pulse, 10'b1000000000);
    for (int k = 0; k < DEPTH; k++) run_beats(k + 1);
    check("R10 in-order lengths", err_sticky, 10'b1000000000);
    send_beat(1'b1);
    check("R10 dropped burst not queued", err_pulse, 10'b0100000000);

    // R12 clear with same-cycle violation
    send_addr(1'b0, 32'h0, 0, 0, 3, 1'b1);
    check("R12 clear keeps new hit", err_sticky, 10'b0000000001);
    run_beats(1);

    // R13 reset mid-burst empties queue and flags
    send_addr(1'b1, 32'h0, 3, 0, 1, 1'b0);
    send_beat(1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R13 flags cleared", err_sticky, 10'd0);
    send_beat(1'b1);
    check("R13 queue emptied", err_pulse, 10'b0100000000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule